// File: doc/BRIEF.md
# Nibble-serial GHASH multiply engine

This block keeps a 128-bit GHASH accumulator X and updates it one block at a time by multiplication with a hash key H in GF(2^128). It uses the bit-reflected convention of GCM. The multiply is table driven. Before hashing, software or a helper loads 16 precomputed multiples of H into a key table through a write port. Entry n holds H times the field element whose top four bits (127..124) are n and whose other bits are zero.

After the table is loaded, each accepted block takes one of two paths:
- In hash mode the block is XORed into X and the sum is multiplied by H.
- In multiply-only mode the current X is multiplied by H and the input data is ignored.

The engine consumes the operand four bits at a time with one step per clock, so one multiply takes 32 cycles. A clear input returns X to zero before a new message starts. X is always visible on the output, and a one-cycle done pulse marks each update.

Top module: `ghash_nib_engine`

## Requirements
- R1: After reset, x_out is zero, done is low and in_ready is high.
- R2: A write with tbl_we high stores tbl_wdata into table entry tbl_addr at the clock edge. The entry is used whenever the current nibble value equals tbl_addr. Writes are only made while no multiply is in progress.
- R3: The operand's 32 nibbles are used in the order of their bit positions, starting from the lowest. Nibble k is operand bits [4k+3:4k], so byte 15 (bits 7..0) comes first, with its low nibble used before its high nibble, and byte 0's high nibble comes last.
- R4: The first step loads the accumulator Z with the table entry for nibble 0. Each later step k sets Z to (Z >> 4), XORs the remainder constant into bits 127..112, and then XORs in the table entry for nibble k.
- R5: The remainder constant is chosen by the four bits Z[3:0] that the shift removes. Indices 1, 2, 4 and 8 give 1C20, 3840, 7080 and E100 (hex). Any other index gives the XOR of the constants for its set bits, and index 0 gives 0000.
- R6: With in_mode = 0 (hash), an accepted block sets X to (X xor in_data) times H.
- R7: With in_mode = 1 (multiply-only), an accepted block sets X to X times H, and in_data has no effect on the result.
- R8: A block is accepted at a rising edge where in_valid and in_ready are both high. x_out takes the new value, and done is high, in the cycle that follows the 31st rising edge after the accepting edge.
- R9: in_ready is low from the cycle after acceptance until done rises. done is high for exactly one cycle per multiply.
- R10: While idle, clear high sets X to zero at the next edge, and in_ready is low while clear is high. A clear during a multiply has no effect on it.
- R11: x_out changes only in a done cycle or in the cycle after an idle clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Key table write enable |
| tbl_addr | input | 4 | Key table entry index |
| tbl_wdata | input | 128 | Key table entry value |
| clear | input | 1 | Zero the accumulator when idle |
| in_valid | input | 1 | Input block offered |
| in_mode | input | 1 | 0 = hash (XOR then multiply), 1 = multiply-only |
| in_data | input | 128 | Input block, byte 0 in bits 127..120 |
| in_ready | output | 1 | Engine can accept a block |
| x_out | output | 128 | Current accumulator X |
| done | output | 1 | One-cycle pulse when X has been updated |

## Verification
The assertions take three things for granted about the inputs:
- The key table is written only while the engine is idle.
- clear is low in the cycle right after reset, so the hold check does not see a stale clear.
- A clear during a multiply is a single pulse that ends before done.

The stimulus keeps to these by loading every table between multiplies, raising clear mid-multiply only for one cycle well before the last step, and holding clear low during reset. Within those limits the random sequence mixes both modes, fresh keys and idle clears. Every result is compared with a bit-serial product computed in the bench.

// File: rtl/ghash_nib_pkg.sv
package ghash_nib_pkg;
    parameter int GH_W     = 128;
    parameter int GH_NIB   = 4;
    parameter int GH_REM_W = 16;
    localparam int GH_ENTRIES = 1 << GH_NIB;
    localparam int GH_STEPS   = GH_W / GH_NIB;
    localparam int GH_CNT_W   = $clog2(GH_STEPS);
    localparam logic [GH_REM_W-1:0] GH_REM_SEED = 16'hE100;

    typedef struct packed {
        logic                busy;
        logic [GH_CNT_W-1:0] cnt;
        logic [GH_W-1:0]     op;
        logic [GH_W-1:0]     z;
        logic [GH_W-1:0]     x;
        logic                done;
    } eng_state_t;

    // Remainder constant for a nibble shifted out of the accumulator.
    function automatic logic [GH_REM_W-1:0] gh_rem(input logic [GH_NIB-1:0] n);
        logic [GH_REM_W-1:0] r;
        r = '0;
        for (int b = 0; b < GH_NIB; b++) begin
            if (n[b]) r = r ^ (GH_REM_SEED >> (GH_NIB - 1 - b));
        end
        return r;
    endfunction
endpackage

// File: rtl/ghash_rem_lut.sv
module ghash_rem_lut
    import ghash_nib_pkg::*;
(
    input  logic [GH_NIB-1:0]   idx,
    output logic [GH_REM_W-1:0] rem
);
    logic [GH_REM_W-1:0] lut [GH_ENTRIES];

    for (genvar i = 0; i < GH_ENTRIES; i++) begin : g_rem
        assign lut[i] = gh_rem(GH_NIB'(i));
    end

    assign rem = lut[idx];
endmodule

// File: rtl/ghash_key_table.sv
module ghash_key_table
    import ghash_nib_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [GH_NIB-1:0] waddr,
    input  logic [GH_W-1:0]   wdata,
    input  logic [GH_NIB-1:0] raddr,
    output logic [GH_W-1:0]   rdata
);
    logic [GH_W-1:0] mem_q [GH_ENTRIES];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ghash_nib_step.sv
module ghash_nib_step
    import ghash_nib_pkg::*;
(
    input  logic [GH_W-1:0] z_in,
    input  logic [GH_W-1:0] entry,
    output logic [GH_W-1:0] z_out
);
    logic [GH_REM_W-1:0] rem;

    ghash_rem_lut u_rem (
        .idx (z_in[GH_NIB-1:0]),
        .rem (rem)
    );

    always_comb begin
        z_out = (z_in >> GH_NIB) ^ {rem, {(GH_W-GH_REM_W){1'b0}}} ^ entry;
    end
endmodule

// File: rtl/ghash_nib_engine.sv
module ghash_nib_engine
    import ghash_nib_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [GH_NIB-1:0] tbl_addr,
    input  logic [GH_W-1:0]   tbl_wdata,
    input  logic              clear,
    input  logic              in_valid,
    input  logic              in_mode,
    input  logic [GH_W-1:0]   in_data,
    output logic              in_ready,
    output logic [GH_W-1:0]   x_out,
    output logic              done
);
    localparam logic [GH_CNT_W-1:0] LAST_CNT = GH_CNT_W'(GH_STEPS - 1);

    eng_state_t s_d, s_q;
    logic              busy;
    logic              accept;
    logic [GH_W-1:0]   operand;
    logic [GH_NIB-1:0] rd_idx;
    logic [GH_W-1:0]   rd_entry;
    logic [GH_W-1:0]   step_z;

    assign busy     = s_q.busy;
    assign in_ready = !busy && !clear;
    assign accept   = in_valid && in_ready;
    assign operand  = in_mode ? s_q.x : (s_q.x ^ in_data);
    assign rd_idx   = busy ? s_q.op[GH_NIB-1:0] : operand[GH_NIB-1:0];

    ghash_key_table u_tbl (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_wdata),
        .raddr (rd_idx),
        .rdata (rd_entry)
    );

    ghash_nib_step u_step (
        .z_in  (s_q.z),
        .entry (rd_entry),
        .z_out (step_z)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!s_q.busy) begin
            if (clear) begin
                s_d.x = '0;
            end else if (accept) begin
                s_d.busy = 1'b1;
                s_d.cnt  = GH_CNT_W'(1);
                s_d.op   = operand >> GH_NIB;
                s_d.z    = rd_entry;
            end
        end else begin
            s_d.z  = step_z;
            s_d.op = s_q.op >> GH_NIB;
            if (s_q.cnt == LAST_CNT) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
                s_d.x    = step_z;
                s_d.done = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign x_out = s_q.x;
    assign done  = s_q.done;
endmodule

// File: rtl/ghash_nib_engine_chk.sv
module ghash_nib_engine_chk
    import ghash_nib_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            tbl_we,
    input logic            clear,
    input logic            in_valid,
    input logic            in_ready,
    input logic [GH_W-1:0] x_out,
    input logic            done,
    input logic            busy
);
    localparam int LAT_W = GH_CNT_W + 2;
    localparam logic [LAT_W-1:0] LAT_END = LAT_W'(GH_STEPS);

    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                    lat_q <= '0;
        else if (in_valid && in_ready) lat_q <= LAT_W'(1);
        else if (lat_q == LAT_END)     lat_q <= '0;
        else if (lat_q != '0)          lat_q <= lat_q + 1'b1;
    end

    p_tbl_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> !busy);
    p_done_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LAT_END));
    p_done_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q == LAT_END) |-> done);
    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !busy) |=> (x_out == '0));
    p_clear_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !in_ready);
    p_x_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(clear)) |-> $stable(x_out));
endmodule

bind ghash_nib_engine ghash_nib_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tbl_we   (tbl_we),
    .clear    (clear),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .x_out    (x_out),
    .done     (done),
    .busy     (busy)
);

// File: tb/sim_ghash_nib_engine.sv
`timescale 1ns/1ps
module sim_ghash_nib_engine;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         tbl_we;
    logic [3:0]   tbl_addr;
    logic [127:0] tbl_wdata;
    logic         clear;
    logic         in_valid;
    logic         in_mode;
    logic [127:0] in_data;
    logic         in_ready;
    logic [127:0] x_out;
    logic         done;

    int n_chk = 0;
    int n_bad = 0;
    logic [127:0] xm;
    logic [127:0] hk;

    always #2.5 clk = ~clk;

    ghash_nib_engine u0 (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .clear(clear), .in_valid(in_valid),
        .in_mode(in_mode), .in_data(in_data), .in_ready(in_ready),
        .x_out(x_out), .done(done)
    );

    // Bit-serial reference product, bit-reflected convention.
    function automatic logic [127:0] gf_mul(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] z = '0;
        logic [127:0] v = b;
        for (int i = 0; i < 128; i++) begin
            if (a[127-i]) z = z ^ v;
            if (v[0]) v = (v >> 1) ^ {8'hE1, 120'b0};
            else      v = v >> 1;
        end
        return z;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R2: table entry n = H * element with nibble n in bits 127..124
    task automatic load_key(input logic [127:0] h);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            tbl_we    = 1'b1;
            tbl_addr  = 4'(i);
            tbl_wdata = gf_mul({4'(i), 124'b0}, h);
        end
        @(negedge clk);
        tbl_we = 1'b0;
        hk = h;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        #0.5;
        check(in_ready == 1'b0, "R10 ready low under clear", {127'b0, in_ready}, 128'd0);
        @(posedge clk);
        @(negedge clk);
        clear = 1'b0;
        check(x_out == '0, "R10 idle clear zeroes X", x_out, 128'd0);
        xm = '0;
    endtask

    task automatic run_op(input bit mode, input logic [127:0] data,
                          input int clr_at, input string tag);
        logic [127:0] exp;
        logic [127:0] held;
        int n;
        exp = gf_mul(mode ? xm : (xm ^ data), hk);
        @(negedge clk);
        in_valid = 1'b1;
        in_mode  = mode;
        in_data  = data;
        #0.5;
        check(in_ready == 1'b1, "R9 ready while idle", {127'b0, in_ready}, 128'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = rnd128();
        check(in_ready == 1'b0, "R9 ready low after accept", {127'b0, in_ready}, 128'd0);
        n = 0;
        while (!done && n < 40) begin
            clear = (n == clr_at);
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        clear = 1'b0;
        check(n == 31, "R8 done after 31 edges", 128'(n), 128'd31);
        check(x_out == exp, tag, x_out, exp);
        check(in_ready == 1'b1, "R9 ready back at done", {127'b0, in_ready}, 128'd1);
        held = x_out;
        @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R9 done single cycle", {127'b0, done}, 128'd0);
        check(x_out == held, "R11 X held after done", x_out, held);
        xm = exp;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0;
        clear = 1'b0; in_valid = 1'b0; in_mode = 1'b0; in_data = '0;
        xm = '0; hk = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(x_out == '0, "R1 reset X", x_out, 128'd0);
        check(done == 1'b0, "R1 reset done", {127'b0, done}, 128'd0);
        check(in_ready == 1'b1, "R1 reset ready", {127'b0, in_ready}, 128'd1);
        rst_n = 1'b1;

        // Identity key: product equals operand (R6, R7)
        load_key({1'b1, 127'b0});
        run_op(1'b0, 128'h0123456789ABCDEF_FEDCBA9876543210, -1, "R6 hash with unit key");
        run_op(1'b1, rnd128(), -1, "R7 data ignored in multiply-only");
        do_clear();

        // Single-nibble operands expose ordering and remainder (R3, R4, R5)
        load_key(rnd128());
        run_op(1'b0, 128'h5, -1, "R3 lowest nibble of byte 15");
        do_clear();
        run_op(1'b0, {4'hA, 124'b0}, -1, "R3 high nibble of byte 0");
        do_clear();
        load_key({127'b0, 1'b1});
        run_op(1'b0, 128'hF0F0_0000_0000_0000_0000_0000_0000_000F, -1, "R5 reduction heavy key");
        run_op(1'b1, '0, -1, "R4 chained multiply");
        run_op(1'b0, rnd128(), 10, "R10 clear during multiply ignored");

        // R2: new key contents take effect
        load_key(rnd128());
        run_op(1'b0, rnd128(), -1, "R2 reloaded table");

        for (int it = 0; it < 48; it++) begin
            if (it % 8 == 0) load_key(rnd128());
            if ($urandom_range(0, 9) == 0) do_clear();
            run_op(1'($urandom_range(0, 3) == 0), rnd128(),
                   ($urandom_range(0, 4) == 0) ? int'($urandom_range(1, 20)) : -1,
                   "R6 R7 random block");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule